// File: doc/BRIEF.md
# Multi-Lane Duty-Cycle Calibration Sequencer

This block runs one duty-cycle calibration pass over a group of clock lanes. On a `go` pulse it freezes each lane's clock-loop update and clears that lane's good flag. It then sends a start command to every lane in the same cycle. Only after that does it visit the lanes one at a time, polling each at a fixed pace until the lane reports completion. A completed lane either passes, and its code joins a running sum, or fails, and it is marked in a fail mask with a one-cycle warning.

Once every lane has completed, a small iterative divider turns the sum into the mean code of the passing lanes. Each failing lane is then handed, one at a time, to an external recovery search seeded with that mean. When the last search has finished, the loop update is re-enabled on every lane. A lane that never completes within the poll budget aborts the whole pass.

The lane calibrators and the recovery engine sit outside this block. The poll and recovery-launch paths are valid/ready channels. A request holds its valid signal, with its payload unchanged, until the responder raises ready; the response is taken only in a cycle where both are high. A responder may hold ready low for any number of cycles, and the sequencer simply waits.

Top module: `lane_cal_mgr`

## Requirements
- R1: After reset: `busy`, `cal_done`, `timeout`, `poll_valid` and `rec_valid` are low, and `upd_en` is all ones.
- R2: After `go`, all `upd_en` bits are driven low and `good_clr` pulses for every lane, all before any start command. `upd_en` stays low while any poll is outstanding.
- R3: Start commands go to all lanes in a single one-cycle `lane_start` pulse, before the first poll. `start_word` carries the mid-range code in bits 15:8 (0x80 for 8-bit codes), the enable flag at bit 7 and the present flag at bit 5, giving 0x80A0.
- R4: Lanes are polled in ascending index order. No lane is polled until every lower-numbered lane has reported done. At least POLL_GAP idle cycles separate consecutive poll handshakes.
- R5: If a lane has not reported done after POLL_LIMIT accepted polls, `timeout` rises and `busy` falls. No further polls or recovery launches follow, and `upd_en` stays low.
- R6: `avg` is the floor of (sum of the passing lanes' codes) divided by (number of passing lanes).
- R7: A lane that reports done with its error bit set has its `fail_mask` bit set, and `warn` pulses for one cycle for that lane. A passing lane leaves its mask bit clear.
- R8: If every lane fails, `avg` is 0 and `all_fail` is set. `all_fail` then stays set until reset.
- R9: Each failing lane is launched for recovery exactly once, in ascending index order, with `rec_seed` equal to `avg`. The next launch waits for `rec_done`.
- R10: After the last recovery finishes (or at once if none failed), `upd_en` returns to all ones, `busy` falls and `cal_done` rises.
- R11: `poll_valid` and `rec_valid` hold their payloads stable until the matching ready is seen. Poll responses count only when `poll_valid` and `poll_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Pulse to begin a calibration pass when idle |
| upd_en | output | NLANES | Per-lane clock-loop update enable |
| good_clr | output | NLANES | Per-lane pulse that clears the loop-good flag |
| lane_start | output | NLANES | Per-lane start-command pulse |
| start_word | output | CODE_W+8 | Control word sent with the start command |
| poll_valid | output | 1 | Poll request valid |
| poll_ready | input | 1 | Poll responder ready; response valid in the same cycle |
| poll_lane | output | $clog2(NLANES) | Lane being polled |
| resp_done | input | 1 | Polled lane has finished |
| resp_err | input | 1 | Polled lane finished with an error |
| resp_code | input | CODE_W | Polled lane's calibrated code |
| rec_valid | output | 1 | Recovery launch valid |
| rec_ready | input | 1 | Recovery engine accepts the launch |
| rec_lane | output | $clog2(NLANES) | Lane to recover |
| rec_seed | output | CODE_W | Seed code for the recovery search |
| rec_done | input | 1 | Recovery search finished |
| busy | output | 1 | A pass is in progress |
| cal_done | output | 1 | Last pass completed normally |
| timeout | output | 1 | Last pass aborted on the poll budget |
| warn | output | 1 | One-cycle recovered-failure warning |
| fail_mask | output | NLANES | Lanes that failed in the current or last pass |
| all_fail | output | 1 | Sticky: some pass had no passing lane |
| avg | output | CODE_W | Mean code of the passing lanes |

## Verification
The bench builds the block with four lanes, a poll budget of six and a two-cycle poll gap. With these values, a lane stuck at not-done reaches the timeout in a few dozen cycles. All-pass, mixed, all-fail and full-scale-code passes each finish quickly. Because the divisor ranges over one to four, it exercises both exact and truncating quotients. In one pass the poll responder withholds ready on a fixed pattern, which tests the valid/ready holding rules together with the gap and ordering checks.

// File: rtl/lane_cal_pkg.sv
package lane_cal_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PREP, S_START, S_GAP, S_POLL, S_NEXT,
    S_DIV, S_DIVW, S_PICK, S_RREQ, S_RWAIT, S_RESTORE
  } cal_state_t;

  // Low byte of the start word: flag positions decoded by the lanes
  localparam int CTRL_LOW_W    = 8;
  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_PRES_BIT = 5;
endpackage

// File: rtl/lane_cal_div.sv
module lane_cal_div #(
  parameter int NUM_W = 12,
  parameter int DEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int STEP_W = $clog2(NUM_W + 1);
  localparam int PROD_W = NUM_W + DEN_W;

  logic [NUM_W-1:0]  q_q, num_q;
  logic [DEN_W-1:0]  r_q, d_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q, done_q;
  logic [DEN_W:0]    r_shift, r_sub;
  logic              take;

  // Restoring division: one quotient bit per cycle
  assign r_shift = {r_q, q_q[NUM_W-1]};
  assign take    = r_shift >= {1'b0, d_q};
  assign r_sub   = r_shift - {1'b0, d_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0; num_q <= '0; r_q <= '0; d_q <= '0;
      step_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        q_q    <= num;
        num_q  <= num;
        d_q    <= den;
        r_q    <= '0;
        step_q <= STEP_W'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        r_q    <= take ? r_sub[DEN_W-1:0] : r_shift[DEN_W-1:0];
        q_q    <= {q_q[NUM_W-2:0], take};
        step_q <= step_q - 1'b1;
        if (step_q == STEP_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = q_q;

  // R6: the quotient is the floor of the latched operands
  p_div_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((PROD_W'(quo) * PROD_W'(d_q)) <= PROD_W'(num_q)) &&
             ((PROD_W'(num_q) - PROD_W'(quo) * PROD_W'(d_q)) < PROD_W'(d_q)));
  p_div_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/lane_cal_pacer.sv
module lane_cal_pacer #(
  parameter int POLL_LIMIT = 384,
  parameter int POLL_GAP   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fire,
  input  logic clr,
  output logic gap_done,
  output logic limit_hit
);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  logic [GAP_W-1:0] gap_q;
  logic [CNT_W-1:0] polls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= GAP_W'(POLL_GAP - 1);
      polls_q <= '0;
    end else begin
      if (!run)              gap_q <= GAP_W'(POLL_GAP - 1);
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
      if (clr)               polls_q <= '0;
      else if (fire)         polls_q <= polls_q + 1'b1;
    end
  end

  assign gap_done  = run && (gap_q == '0);
  assign limit_hit = (polls_q == CNT_W'(POLL_LIMIT - 1));

  // R5: no lane is polled beyond its budget
  p_poll_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> polls_q < CNT_W'(POLL_LIMIT));
endmodule

// File: rtl/lane_cal_pick.sv
module lane_cal_pick #(
  parameter int NLANES = 10,
  parameter int LANE_W = 4
) (
  input  logic [NLANES-1:0] mask,
  output logic [LANE_W-1:0] idx,
  output logic              any
);
  // Lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = NLANES - 1; i >= 0; i--)
      if (mask[i]) idx = LANE_W'(i);
  end
  assign any = |mask;
endmodule

// File: rtl/lane_cal_mgr.sv
module lane_cal_mgr
  import lane_cal_pkg::*;
#(
  parameter int NLANES     = 10,
  parameter int CODE_W     = 8,
  parameter int POLL_LIMIT = 384,
  parameter int POLL_GAP   = 20,
  localparam int LANE_W    = (NLANES > 1) ? $clog2(NLANES) : 1,
  localparam int WORD_W    = CODE_W + CTRL_LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic [NLANES-1:0] upd_en,
  output logic [NLANES-1:0] good_clr,
  output logic [NLANES-1:0] lane_start,
  output logic [WORD_W-1:0] start_word,
  output logic              poll_valid,
  input  logic              poll_ready,
  output logic [LANE_W-1:0] poll_lane,
  input  logic              resp_done,
  input  logic              resp_err,
  input  logic [CODE_W-1:0] resp_code,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [LANE_W-1:0] rec_lane,
  output logic [CODE_W-1:0] rec_seed,
  input  logic              rec_done,
  output logic              busy,
  output logic              cal_done,
  output logic              timeout,
  output logic              warn,
  output logic [NLANES-1:0] fail_mask,
  output logic              all_fail,
  output logic [CODE_W-1:0] avg
);
  localparam int CNT_W = $clog2(NLANES + 1);
  localparam int SUM_W = CODE_W + CNT_W;
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CTRL_LOW_W-1:0] CTRL_LOW =
    (CTRL_LOW_W'(1) << CTRL_EN_BIT) | (CTRL_LOW_W'(1) << CTRL_PRES_BIT);

  cal_state_t        state_q;
  logic [LANE_W-1:0] lane_q, rec_lane_q;
  logic [SUM_W-1:0]  sum_q;
  logic [NLANES-1:0] fail_q, pend_q, upd_q, gclr_q, start_q;
  logic [CODE_W-1:0] avg_q;
  logic              busy_q, done_q, to_q, warn_q, allf_q;
  logic [CNT_W-1:0]  fail_cnt, pass_cnt;
  logic              gap_done, limit_hit, poll_fire;
  logic              div_start, div_busy, div_done;
  logic [SUM_W-1:0]  div_quo;
  logic [LANE_W-1:0] pick_idx;
  logic              pick_any;

  always_comb begin
    fail_cnt = '0;
    for (int i = 0; i < NLANES; i++) fail_cnt = fail_cnt + CNT_W'(fail_q[i]);
  end
  assign pass_cnt  = CNT_W'(NLANES) - fail_cnt;
  assign poll_fire = (state_q == S_POLL) && poll_ready;
  assign div_start = (state_q == S_DIV) && (pass_cnt != '0);

  lane_cal_pacer #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(state_q == S_GAP), .fire(poll_fire),
    .clr((state_q == S_START) || (state_q == S_NEXT)),
    .gap_done(gap_done), .limit_hit(limit_hit));

  lane_cal_div #(.NUM_W(SUM_W), .DEN_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(sum_q), .den(pass_cnt),
    .busy(div_busy), .done(div_done), .quo(div_quo));

  lane_cal_pick #(.NLANES(NLANES), .LANE_W(LANE_W)) u_pick (
    .mask(pend_q), .idx(pick_idx), .any(pick_any));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; lane_q <= '0; rec_lane_q <= '0; sum_q <= '0;
      fail_q <= '0; pend_q <= '0; upd_q <= '1; gclr_q <= '0; start_q <= '0;
      avg_q <= '0; busy_q <= 1'b0; done_q <= 1'b0; to_q <= 1'b0;
      warn_q <= 1'b0; allf_q <= 1'b0;
    end else begin
      warn_q  <= 1'b0;
      gclr_q  <= '0;
      start_q <= '0;
      unique case (state_q)
        S_IDLE: if (go) begin
          busy_q <= 1'b1; done_q <= 1'b0; to_q <= 1'b0;
          fail_q <= '0; sum_q <= '0; lane_q <= '0;
          state_q <= S_PREP;
        end
        S_PREP: begin
          upd_q <= '0; gclr_q <= '1; state_q <= S_START;
        end
        S_START: begin
          start_q <= '1; state_q <= S_GAP;
        end
        S_GAP: if (gap_done) state_q <= S_POLL;
        S_POLL: if (poll_ready) begin
          if (resp_done) begin
            if (resp_err) begin
              fail_q[lane_q] <= 1'b1;
              warn_q         <= 1'b1;
            end else begin
              sum_q <= sum_q + SUM_W'(resp_code);
            end
            state_q <= S_NEXT;
          end else if (limit_hit) begin
            to_q <= 1'b1; busy_q <= 1'b0; state_q <= S_IDLE;
          end else begin
            state_q <= S_GAP;
          end
        end
        S_NEXT: if (lane_q == LANE_W'(NLANES - 1)) state_q <= S_DIV;
                else begin lane_q <= lane_q + 1'b1; state_q <= S_GAP; end
        S_DIV: begin
          pend_q <= fail_q;
          if (pass_cnt == '0) begin
            avg_q <= '0; allf_q <= 1'b1; state_q <= S_PICK;
          end else begin
            state_q <= S_DIVW;
          end
        end
        S_DIVW: if (div_done) begin
          avg_q <= div_quo[CODE_W-1:0]; state_q <= S_PICK;
        end
        S_PICK: if (pick_any) begin
          rec_lane_q <= pick_idx; state_q <= S_RREQ;
        end else begin
          state_q <= S_RESTORE;
        end
        S_RREQ: if (rec_ready) begin
          pend_q[rec_lane_q] <= 1'b0; state_q <= S_RWAIT;
        end
        S_RWAIT: if (rec_done) state_q <= S_PICK;
        S_RESTORE: begin
          upd_q <= '1; busy_q <= 1'b0; done_q <= 1'b1; state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign upd_en     = upd_q;
  assign good_clr   = gclr_q;
  assign lane_start = start_q;
  assign start_word = {MID_CODE, CTRL_LOW};
  assign poll_valid = (state_q == S_POLL);
  assign poll_lane  = lane_q;
  assign rec_valid  = (state_q == S_RREQ);
  assign rec_lane   = rec_lane_q;
  assign rec_seed   = avg_q;
  assign busy       = busy_q;
  assign cal_done   = done_q;
  assign timeout    = to_q;
  assign warn       = warn_q;
  assign fail_mask  = fail_q;
  assign all_fail   = allf_q;
  assign avg        = avg_q;

  p_poll_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    poll_valid && !poll_ready |=> poll_valid && $stable(poll_lane));
  p_rec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_lane) && $stable(rec_seed));
  p_poll_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    poll_valid |-> upd_en == '0);
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_start) |=> lane_start == '0);
  p_timeout_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !poll_valid && !rec_valid && !busy);
  p_warn_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> fail_mask != '0);
  p_allfail_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && (fail_mask == '1) |-> rec_seed == '0);
  p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> upd_en == '1 && !busy);
endmodule

// File: tb/lane_cal_mgr_tb.sv
module lane_cal_mgr_tb;
  localparam int N = 4, CW = 8, LIM = 6, GAP = 2;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [N-1:0] upd_en, good_clr, lane_start, fail_mask;
  logic [15:0] start_word;
  logic poll_valid, poll_ready, resp_done, resp_err;
  logic [1:0] poll_lane, rec_lane;
  logic [CW-1:0] resp_code, rec_seed, avg;
  logic rec_valid, rec_done = 1'b0;
  logic busy, cal_done, timeout, warn, all_fail;

  int checks = 0, fails = 0, cyc = 0;
  int need [N]; bit errf [N]; logic [CW-1:0] codes [N];
  int pcount [N]; bit dseen [N];
  int start_cnt, start_cyc, first_poll, last_poll, order_err, gap_err, prep_err;
  int warn_cnt, rec_n, rec_fin, rec_overlap, rec_wait;
  logic [N-1:0] start_mask, gclr_mask; logic [15:0] word_seen;
  int rec_lanes [8]; int rec_seeds [8];
  bit stall_mode = 1'b0;

  always #2.5 clk = ~clk;

  assign poll_ready = !(stall_mode && (cyc % 3 == 0));
  assign resp_done  = (need[poll_lane] != 0) && (pcount[poll_lane] + 1 >= need[poll_lane]);
  assign resp_err   = errf[poll_lane];
  assign resp_code  = codes[poll_lane];

  lane_cal_mgr #(.NLANES(N), .CODE_W(CW), .POLL_LIMIT(LIM), .POLL_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .upd_en(upd_en), .good_clr(good_clr),
    .lane_start(lane_start), .start_word(start_word), .poll_valid(poll_valid),
    .poll_ready(poll_ready), .poll_lane(poll_lane), .resp_done(resp_done),
    .resp_err(resp_err), .resp_code(resp_code), .rec_valid(rec_valid),
    .rec_ready(1'b1), .rec_lane(rec_lane), .rec_seed(rec_seed), .rec_done(rec_done),
    .busy(busy), .cal_done(cal_done), .timeout(timeout), .warn(warn),
    .fail_mask(fail_mask), .all_fail(all_fail), .avg(avg));

  // Monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (|good_clr) gclr_mask = gclr_mask | good_clr;
      if (|lane_start) begin
        start_cnt++; start_mask = start_mask | lane_start; word_seen = start_word;
        start_cyc = cyc;
        if (upd_en != '0 || gclr_mask != '1) prep_err++;
      end
      if (poll_valid && poll_ready) begin
        int exp_l = N;
        for (int i = N - 1; i >= 0; i--) if (!dseen[i]) exp_l = i;
        if (int'(poll_lane) != exp_l) order_err++;
        if (last_poll >= 0 && cyc - last_poll < GAP + 1) gap_err++;
        if (first_poll < 0) first_poll = cyc;
        if (upd_en != '0) prep_err++;
        last_poll = cyc;
        if (resp_done) dseen[poll_lane] = 1'b1;
        pcount[poll_lane] = pcount[poll_lane] + 1;
      end
      if (warn) warn_cnt++;
      if (rec_valid) begin
        if (rec_n != rec_fin) rec_overlap++;
        if (rec_n < 8) begin rec_lanes[rec_n] = rec_lane; rec_seeds[rec_n] = rec_seed; end
        rec_n++;
      end
    end
  end

  // Recovery engine model: finishes three cycles after launch
  always @(negedge clk) begin
    rec_done <= 1'b0;
    if (rec_n != rec_fin) begin
      rec_wait++;
      if (rec_wait == 3) begin rec_done <= 1'b1; rec_wait = 0; rec_fin++; end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int i = 0; i < N; i++) begin pcount[i] = 0; dseen[i] = 1'b0; end
    start_cnt = 0; start_cyc = -1; first_poll = -1; last_poll = -1;
    order_err = 0; gap_err = 0; prep_err = 0; warn_cnt = 0;
    rec_n = 0; rec_fin = 0; rec_overlap = 0; rec_wait = 0;
    start_mask = '0; gclr_mask = '0; word_seen = '0;
  endtask

  task automatic setup(int n0, int n1, int n2, int n3, bit [3:0] e,
                       logic [CW-1:0] c0, logic [CW-1:0] c1, logic [CW-1:0] c2, logic [CW-1:0] c3);
    need[0] = n0; need[1] = n1; need[2] = n2; need[3] = n3;
    for (int i = 0; i < N; i++) errf[i] = e[i];
    codes[0] = c0; codes[1] = c1; codes[2] = c2; codes[3] = c3;
    clear_log();
  endtask

  task automatic run_pass();
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    while (!(cal_done || timeout)) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic common_checks(int total_polls);
    int sum = 0;
    for (int i = 0; i < N; i++) sum += pcount[i];
    chk(sum == total_polls, "R11 accepted polls", sum, total_polls);
    chk(order_err == 0, "R4 lane order", order_err, 0);
    chk(gap_err == 0, "R4 poll gap", gap_err, 0);
    chk(prep_err == 0, "R2 freeze before start/poll", prep_err, 0);
    chk(gclr_mask == '1, "R2 good flag clear", gclr_mask, 15);
    chk(start_cnt == 1 && start_mask == '1, "R3 single start pulse", start_cnt, 1);
    chk(word_seen == 16'h80A0, "R3 start word", word_seen, 16'h80A0);
    chk(start_cyc >= 0 && start_cyc < first_poll, "R3 start before poll", start_cyc, first_poll);
  endtask

  task automatic t_reset();
    chk(!busy && !cal_done && !timeout, "R1 reset status", busy, 0);
    chk(upd_en == '1, "R1 reset update enable", upd_en, 15);
    chk(!poll_valid && !rec_valid, "R1 no requests", poll_valid, 0);
  endtask

  task automatic t_all_pass();
    setup(1, 3, 2, 1, 4'b0000, 8'd10, 8'd20, 8'd30, 8'd41);
    run_pass();
    common_checks(7);
    chk(avg == 8'd25, "R6 mean 101/4", avg, 25);
    chk(fail_mask == '0 && warn_cnt == 0, "R7 no failures", warn_cnt, 0);
    chk(rec_n == 0, "R9 no recovery", rec_n, 0);
    chk(upd_en == '1 && cal_done && !busy, "R10 restore", upd_en, 15);
    chk(!all_fail, "R8 flag clear", all_fail, 0);
  endtask

  task automatic t_mixed();
    stall_mode = 1'b1;
    setup(2, 1, 4, 2, 4'b1010, 8'd7, 8'd99, 8'd10, 8'd200);
    run_pass();
    stall_mode = 1'b0;
    common_checks(9);
    chk(avg == 8'd8, "R6 mean 17/2 truncated", avg, 8);
    chk(fail_mask == 4'b1010, "R7 fail mask", fail_mask, 10);
    chk(warn_cnt == 2, "R7 warning pulses", warn_cnt, 2);
    chk(rec_n == 2, "R9 launch count", rec_n, 2);
    chk(rec_lanes[0] == 1 && rec_lanes[1] == 3, "R9 launch order", rec_lanes[1], 3);
    chk(rec_seeds[0] == 8 && rec_seeds[1] == 8, "R9 seed", rec_seeds[0], 8);
    chk(rec_overlap == 0, "R9 one at a time", rec_overlap, 0);
    chk(upd_en == '1 && cal_done, "R10 restore after recovery", upd_en, 15);
  endtask

  task automatic t_all_fail();
    setup(1, 1, 1, 1, 4'b1111, 8'd5, 8'd6, 8'd7, 8'd8);
    run_pass();
    chk(avg == 0, "R8 zero mean", avg, 0);
    chk(all_fail, "R8 all-fail flag", all_fail, 1);
    chk(rec_n == 4 && rec_lanes[0] == 0 && rec_lanes[3] == 3, "R9 all lanes recovered", rec_n, 4);
    chk(rec_seeds[2] == 0, "R9 zero seed", rec_seeds[2], 0);
    chk(warn_cnt == 4, "R7 four warnings", warn_cnt, 4);
  endtask

  task automatic t_timeout();
    setup(1, 1, 0, 1, 4'b0000, 8'd1, 8'd2, 8'd3, 8'd4);
    run_pass();
    chk(timeout && !busy && !cal_done, "R5 timeout status", timeout, 1);
    chk(pcount[2] == LIM, "R5 poll budget", pcount[2], LIM);
    chk(pcount[3] == 0 && rec_n == 0, "R5 nothing after abort", pcount[3], 0);
    chk(upd_en == '0, "R5 update left frozen", upd_en, 0);
    chk(all_fail, "R8 flag sticky", all_fail, 1);
  endtask

  task automatic t_full_scale();
    setup(2, 2, 1, 3, 4'b0000, 8'd255, 8'd255, 8'd255, 8'd255);
    run_pass();
    chk(!timeout && cal_done, "R10 completion after abort", timeout, 0);
    chk(avg == 8'd255, "R6 full-scale mean", avg, 255);
    chk(order_err == 0 && gap_err == 0, "R4 order and gap", order_err, 0);
  endtask

  initial begin
    clear_log();
    for (int i = 0; i < N; i++) begin need[i] = 1; errf[i] = 1'b0; codes[i] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_all_pass();
    t_mixed();
    t_all_fail();
    t_timeout();
    t_full_scale();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule